// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block turns one command request into the series of unlock-and-command bus writes that a parallel NOR flash expects before it starts a byte program, a whole-device erase or a sector erase. The requester presents a command code, a target address and a data byte, and pulses a request. The sequencer then owns the flash write bus. For each write in turn it drives address, data, chip-enable and write-enable. When the last write has finished it signals completion for one cycle.

Every sequence starts with the same two unlock writes. Program then needs two more writes. Both erase flavours need four more. Each write uses the same shape: one setup clock, a write-enable low pulse whose length in clocks is set per request, and one hold clock. Address and data do not move across that whole window. The requester has to poll the flash for completion on its own, because this block only issues the writes.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, and at any time the block is idle, flash_ce_no and flash_we_no are 1, and busy_o, done_o, err_o and rej_o are 0.
- R2: Command code 0 (program) issues exactly 4 writes, as address/data pairs: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then addr_i/data_i.
- R3: Command code 1 (whole-device erase) issues exactly 6 writes: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/10h.
- R4: Command code 2 (sector erase) issues the same first five writes as R3. Its sixth write is 30h to addr_i.
- R5: In every write, flash_we_no is low for exactly we_len_i consecutive clocks, where we_len_i is sampled at acceptance. A value of 0 gives a 1-clock pulse.
- R6: flash_ce_no is low, and flash_addr_o and flash_data_o are stable, from one clock before flash_we_no falls until one clock after it rises.
- R7: busy_o rises in the cycle after an accepted request. It stays high for writes*(pulse+2) cycles. It falls in the same cycle that done_o is high, and done_o is high for exactly one cycle.
- R8: A request while busy_o is high is rejected. rej_o pulses for one cycle in the next cycle, and the running sequence goes on unchanged.
- R9: Command code 3 is unknown. It produces no bus write, leaves busy_o low, and pulses err_o in the next cycle.
- R10: flash_we_no is never low while flash_ce_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Command request, one-cycle pulse |
| cmd_i | input | 2 | Command code: 0 program, 1 device erase, 2 sector erase, 3 unknown |
| addr_i | input | ADDR_W | Program or sector address |
| data_i | input | DATA_W | Program data byte |
| we_len_i | input | LEN_W | Write-enable pulse length in clocks (0 counts as 1) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last write of the sequence finished |
| err_o | output | 1 | Unknown command code seen |
| rej_o | output | 1 | Request refused while busy |
| flash_addr_o | output | ADDR_W | Flash address bus |
| flash_data_o | output | DATA_W | Flash data bus |
| flash_ce_no | output | 1 | Flash chip enable, active low |
| flash_we_no | output | 1 | Flash write enable, active low |

## Verification
Suppose the step index is wrong, or the command latched at acceptance is wrong. Then the captured address/data pair is wrong at the very next write-enable fall, within pulse+2 clocks of the fault. Errors in the pulse counter or in the phase state show up as a write-enable pulse of the wrong width, or as address movement around that pulse. They also show up as a total busy time that differs from writes*(pulse+2), and this is caught by the time done_o rises. A sequence that ends early or late changes the write count and the cycle in which done_o appears.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    CMD_PROG       = 2'd0,
    CMD_CHIP_ERASE = 2'd1,
    CMD_SECT_ERASE = 2'd2,
    CMD_BAD        = 2'd3
  } flash_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_HOLD  = 2'd3
  } wr_phase_e;

  localparam int unsigned MAX_STEPS = 6;
  localparam int unsigned STEP_W    = $clog2(MAX_STEPS);

  localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;

  localparam logic [7:0] UNLK_DATA_A = 8'hAA;
  localparam logic [7:0] UNLK_DATA_B = 8'h55;
  localparam logic [7:0] OP_PROG     = 8'hA0;
  localparam logic [7:0] OP_ERASE    = 8'h80;
  localparam logic [7:0] OP_CHIP     = 8'h10;
  localparam logic [7:0] OP_SECT     = 8'h30;

endpackage

// File: rtl/flash_seq_rom.sv
module flash_seq_rom
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8
) (
  input  flash_cmd_e          cmd_i,
  input  logic [STEP_W-1:0]   step_i,
  input  logic [ADDR_W-1:0]   tgt_addr_i,
  input  logic [DATA_W-1:0]   tgt_data_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   data_o,
  output logic                last_o
);

  localparam logic [ADDR_W-1:0] A_A = ADDR_W'(UNLK_ADDR_A);
  localparam logic [ADDR_W-1:0] A_B = ADDR_W'(UNLK_ADDR_B);

  always_comb begin
    addr_o = A_A;
    data_o = DATA_W'(UNLK_DATA_A);
    last_o = 1'b0;
    unique case (step_i)
      STEP_W'(0): ;
      STEP_W'(1): begin
        addr_o = A_B;
        data_o = DATA_W'(UNLK_DATA_B);
      end
      STEP_W'(2): begin
        data_o = (cmd_i == CMD_PROG) ? DATA_W'(OP_PROG) : DATA_W'(OP_ERASE);
      end
      STEP_W'(3): begin
        if (cmd_i == CMD_PROG) begin
          addr_o = tgt_addr_i;
          data_o = tgt_data_i;
          last_o = 1'b1;
        end
      end
      STEP_W'(4): begin
        addr_o = A_B;
        data_o = DATA_W'(UNLK_DATA_B);
      end
      STEP_W'(5): begin
        last_o = 1'b1;
        if (cmd_i == CMD_SECT_ERASE) begin
          addr_o = tgt_addr_i;
          data_o = DATA_W'(OP_SECT);
        end else begin
          data_o = DATA_W'(OP_CHIP);
        end
      end
      default: last_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/flash_wr_timer.sv
module flash_wr_timer
  import flash_seq_pkg::*;
#(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [LEN_W-1:0] len_i,
  output wr_phase_e        phase_o
);

  wr_phase_e        phase_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (go_i) phase_q <= PH_SETUP;
        PH_SETUP: begin
          // zero length is treated as a single-clock pulse
          cnt_q   <= (len_i == '0) ? '0 : len_i - LEN_W'(1);
          phase_q <= PH_PULSE;
        end
        PH_PULSE: begin
          if (cnt_q == '0) phase_q <= PH_HOLD;
          else             cnt_q   <= cnt_q - LEN_W'(1);
        end
        PH_HOLD: phase_q <= go_i ? PH_SETUP : PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  we_len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              rej_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [DATA_W-1:0] flash_data_o,
  output logic              flash_ce_no,
  output logic              flash_we_no
);

  flash_cmd_e        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [LEN_W-1:0]  len_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q, err_q, rej_q;

  wr_phase_e         phase;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;
  logic              rom_last;
  logic              busy, accept, bad_req, advance, finish, go;

  assign busy    = (phase != PH_IDLE);
  assign bad_req = req_i && !busy && (flash_cmd_e'(cmd_i) == CMD_BAD);
  assign accept  = req_i && !busy && (flash_cmd_e'(cmd_i) != CMD_BAD);
  assign advance = (phase == PH_HOLD) && !rom_last;
  assign finish  = (phase == PH_HOLD) &&  rom_last;
  assign go      = accept || advance;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_PROG;
      addr_q <= '0;
      data_q <= '0;
      len_q  <= '0;
      step_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      if (accept) begin
        cmd_q  <= flash_cmd_e'(cmd_i);
        addr_q <= addr_i;
        data_q <= data_i;
        len_q  <= we_len_i;
        step_q <= '0;
      end else if (advance) begin
        step_q <= step_q + STEP_W'(1);
      end
      done_q <= finish;
      err_q  <= bad_req;
      rej_q  <= req_i && busy;
    end
  end

  flash_wr_timer #(.LEN_W(LEN_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .len_i   (len_q),
    .phase_o (phase)
  );

  flash_seq_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rom (
    .cmd_i      (cmd_q),
    .step_i     (step_q),
    .tgt_addr_i (addr_q),
    .tgt_data_i (data_q),
    .addr_o     (rom_addr),
    .data_o     (rom_data),
    .last_o     (rom_last)
  );

  assign busy_o       = busy;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign rej_o        = rej_q;
  assign flash_ce_no  = !busy;
  assign flash_we_no  = (phase != PH_PULSE);
  assign flash_addr_o = busy ? rom_addr : '0;
  assign flash_data_o = busy ? rom_data : '0;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              done_i,
  input logic              err_i,
  input logic              rej_i,
  input logic              ce_ni,
  input logic              we_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic [LEN_W-1:0]  len_q_i
);

  logic [LEN_W:0] low_run;
  logic [LEN_W:0] eff_len;

  assign eff_len = (len_q_i == '0) ? (LEN_W+1)'(1) : {1'b0, len_q_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_run <= '0;
    else if (!we_ni)  low_run <= low_run + (LEN_W+1)'(1);
    else              low_run <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> ce_ni && we_ni);

  p_pulse_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_ni) |-> low_run == eff_len);

  p_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_ni) |-> $stable(addr_i) && $stable(data_i) && $past(!ce_ni));

  p_pulse_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_ni && $past(!we_ni)) |-> $stable(addr_i) && $stable(data_i));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_ni) |-> !ce_ni && $stable(addr_i) && $stable(data_i));

  p_done_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i && $past(busy_i));

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_reject_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_i |-> $past(busy_i));

  p_unknown_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !busy_i && $past(!busy_i));

  p_we_inside_ce_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> !ce_ni);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LEN_W  (LEN_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_i  (busy_o),
  .done_i  (done_o),
  .err_i   (err_o),
  .rej_i   (rej_o),
  .ce_ni   (flash_ce_no),
  .we_ni   (flash_we_no),
  .addr_i  (flash_addr_o),
  .data_i  (flash_data_o),
  .len_q_i (len_q)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic [1:0]        cmd = 2'd0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] data = '0;
  logic [LEN_W-1:0]  wlen = '0;
  logic              busy_o, done_o, err_o, rej_o, ce_n, we_n;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) i_flash_cmd_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_i        (req),
    .cmd_i        (cmd),
    .addr_i       (addr),
    .data_i       (data),
    .we_len_i     (wlen),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .rej_o        (rej_o),
    .flash_addr_o (f_addr),
    .flash_data_o (f_data),
    .flash_ce_no  (ce_n),
    .flash_we_no  (we_n)
  );

  // bus monitor, sampled mid-cycle
  logic [ADDR_W-1:0] m_addr [64];
  logic [DATA_W-1:0] m_data [64];
  int                m_wid  [64];
  int m_wr = 0, m_tmg = 0, m_busy = 0, m_webad = 0, m_low = 0;
  logic              p_we = 1'b1, p_ce = 1'b1;
  logic [ADDR_W-1:0] p_addr = '0;
  logic [DATA_W-1:0] p_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) m_busy++;
      if (!we_n && ce_n) m_webad++;
      if (p_we && !we_n) begin
        m_addr[m_wr % 64] = f_addr;
        m_data[m_wr % 64] = f_data;
        m_low = 1;
        if (p_ce || p_addr != f_addr || p_data != f_data) m_tmg++;
      end else if (!p_we && !we_n) begin
        m_low++;
        if (p_addr != f_addr || p_data != f_data) m_tmg++;
      end else if (!p_we && we_n) begin
        m_wid[m_wr % 64] = m_low;
        if (ce_n || p_addr != f_addr || p_data != f_data) m_tmg++;
        m_wr++;
      end
    end
    p_we = we_n; p_ce = ce_n; p_addr = f_addr; p_data = f_data;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_err++;
      $display("FAIL R7 watchdog actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  // expected pair for write i, built from R2..R4
  task automatic exp_step(input int c, input int i, input logic [ADDR_W-1:0] ta,
                          input logic [DATA_W-1:0] td,
                          output logic [ADDR_W-1:0] ea, output logic [DATA_W-1:0] ed);
    ea = 20'h05555; ed = 8'hAA;
    case (i)
      1: begin ea = 20'h02AAA; ed = 8'h55; end
      2: ed = (c == 0) ? 8'hA0 : 8'h80;
      3: if (c == 0) begin ea = ta; ed = td; end
      4: begin ea = 20'h02AAA; ed = 8'h55; end
      5: if (c == 2) begin ea = ta; ed = 8'h30; end else ed = 8'h10;
      default: ;
    endcase
  endtask

  task automatic issue(input int c, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input int l);
    @(negedge clk);
    req = 1'b1; cmd = 2'(c); addr = a; data = d; wlen = LEN_W'(l);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done(input string rq);
    int k;
    for (k = 0; k < 2000; k++) begin
      if (done_o) break;
      @(negedge clk);
    end
    chk(done_o == 1'b1, rq, "done seen", 32'(done_o), 1);
    chk(busy_o == 1'b0, "R7", "busy low with done", 32'(busy_o), 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R7", "done one cycle", 32'(done_o), 0);
  endtask

  task automatic check_run(input int c, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d, input int l,
                           input int base, input int tb, input int bb, input string rq);
    int nw = (c == 0) ? 4 : 6;
    int ew = (l == 0) ? 1 : l;
    logic [ADDR_W-1:0] ea;
    logic [DATA_W-1:0] ed;
    #1;
    chk(m_wr - base == nw, rq, "write count", 32'(m_wr - base), 32'(nw));
    for (int i = 0; i < nw; i++) begin
      exp_step(c, i, a, d, ea, ed);
      chk(m_addr[(base+i)%64] == ea, rq, $sformatf("addr w%0d", i),
          32'(m_addr[(base+i)%64]), 32'(ea));
      chk(m_data[(base+i)%64] == ed, rq, $sformatf("data w%0d", i),
          32'(m_data[(base+i)%64]), 32'(ed));
      chk(m_wid[(base+i)%64] == ew, "R5", $sformatf("pulse w%0d", i),
          32'(m_wid[(base+i)%64]), 32'(ew));
    end
    chk(m_tmg == tb, "R6", "setup/pulse/hold stability", 32'(m_tmg - tb), 0);
    chk(m_busy - bb == nw * (ew + 2), "R7", "busy cycles",
        32'(m_busy - bb), 32'(nw * (ew + 2)));
  endtask

  task automatic t_reset;
    chk(ce_n == 1'b1 && we_n == 1'b1, "R1", "bus idle in reset", {30'd0, ce_n, we_n}, 3);
    chk({busy_o, done_o, err_o, rej_o} == 4'b0, "R1", "flags in reset",
        32'({busy_o, done_o, err_o, rej_o}), 0);
  endtask

  task automatic t_cmd(input int c, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input int l, input string rq);
    int base = m_wr, tb = m_tmg, bb = m_busy;
    issue(c, a, d, l);
    chk(busy_o == 1'b1, "R7", "busy after accept", 32'(busy_o), 1);
    wait_done(rq);
    check_run(c, a, d, l, base, tb, bb, rq);
    chk(ce_n && we_n && !busy_o, "R1", "idle after run", {30'd0, ce_n, we_n}, 3);
  endtask

  task automatic t_reject;
    int base = m_wr, tb = m_tmg, bb = m_busy;
    issue(0, 20'h0ABCD, 8'h3C, 3);
    repeat (2) @(negedge clk);
    req = 1'b1; cmd = 2'd1; addr = 20'h77777; data = 8'hEE; wlen = 4'd1;
    @(negedge clk);
    req = 1'b0;
    chk(rej_o == 1'b1, "R8", "reject pulse", 32'(rej_o), 1);
    @(negedge clk);
    chk(rej_o == 1'b0, "R8", "reject one cycle", 32'(rej_o), 0);
    wait_done("R8");
    check_run(0, 20'h0ABCD, 8'h3C, 3, base, tb, bb, "R8");
  endtask

  task automatic t_unknown;
    int base = m_wr, bb = m_busy;
    issue(3, 20'h11111, 8'h99, 2);
    chk(err_o == 1'b1, "R9", "error pulse", 32'(err_o), 1);
    chk(busy_o == 1'b0, "R9", "not busy", 32'(busy_o), 0);
    repeat (8) @(negedge clk);
    #1;
    chk(m_wr == base && m_busy == bb, "R9", "no bus writes", 32'(m_wr - base), 0);
    chk(err_o == 1'b0 && ce_n, "R9", "error cleared, ce high", 32'(err_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_cmd(0, 20'h1234F, 8'h5C, 2, "R2");
    t_cmd(1, 20'h00000, 8'h00, 1, "R3");
    t_cmd(2, 20'hA3000, 8'h00, 5, "R4");
    t_cmd(1, 20'h00000, 8'h00, 0, "R5");
    t_cmd(0, 20'hFFFFF, 8'hFF, 15, "R5");
    t_reject;
    t_unknown;
    t_cmd(2, 20'h40000, 8'h00, 1, "R4");
    chk(m_webad == 0, "R10", "we low with ce high", 32'(m_webad), 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule